// File: doc/BRIEF.md
# Sensor Startup Phase Sequencer

This block drives the transmit side of a sensor that reports over a two-wire current-modulated link. After reset it walks through a fixed startup order. The first step is initialization. Then come identification messages with the serial number bytes, a revision/manufacturer byte, the user byte and the separate ninth user bit. Next is a self-test status message, then an optional auto-zero message. After that it sends acceleration samples for as long as it runs. For every message the block builds a 12-bit frame: a 2-bit message type followed by a 10-bit data field. It shifts the frame out as a Manchester-coded bit stream on one line that the current driver follows.

Messages are paced in one of two ways. In free-running mode an internal counter releases one message each `PERIOD` clocks. In synchronous mode only an accepted sync pulse moves the sequencer on. The frame then starts in slot 0, right after the pulse, or in slot 1, `SLOT_GAP` clocks later, so two sensors can share one bus. The pacing mode, slot choice and auto-zero option come from static configuration inputs. They are changed only while the block is in reset.

Top module: `sensor_phase_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `phase_o` reads 0 (initialization), `tx_line` is low and `tx_active` is low.
- R2: Phases advance in the order 0 (init), 1 (device data), 2 (diagnostic), 3 (auto-zero), 4 (normal). The first message opportunity after reset only moves the sequencer from phase 0 to phase 1 and sends nothing.
- R3: The device data phase sends 7 frames of type 2'b00, each with its data zero-extended to 10 bits. The first four are the serial number bytes, least significant byte first. The fifth is the ID byte {2'b00, rev_id[2:0], mfg_id[2:0]}. The sixth is the user byte. The last is the user bit, alone in data bit 0.
- R4: The diagnostic phase sends one frame of type 2'b01 with `selftest_ok` in data bit 0 and the other data bits zero.
- R5: With `az_en` high, the diagnostic frame is followed by one auto-zero frame of type 2'b10 that carries the current acceleration sample. With `az_en` low, the sequencer goes from phase 2 straight to phase 4.
- R6: The normal phase sends frames of type 2'b11 carrying the 10-bit acceleration sample taken when the frame starts. It repeats for as long as the block runs.
- R7: With `sync_en` low, message opportunities occur every `PERIOD` clocks, so consecutive frames start exactly `PERIOD` clocks apart, and `sync_pulse` has no effect.
- R8: With `sync_en` high, no frame is sent without a sync pulse. `tx_active` rises 2 clocks after the clock edge that accepts a pulse when `slot_sel` is 0, and `SLOT_GAP`+2 clocks after it when `slot_sel` is 1.
- R9: A sync pulse that arrives while an accepted pulse is still waiting for its slot, or while a frame is being sent, is dropped. It neither advances the sequencer nor causes a later frame.
- R10: Frames go out most significant bit first, type bits ahead of data. Each bit takes two halves of `HALF_CYC` clocks: a 0 is high then low, a 1 is low then high. `tx_active` is high for exactly 2*12*`HALF_CYC` clocks per frame, and `tx_line` is low whenever `tx_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_en | input | 1 | 1 = advance on sync pulses, 0 = free-running timer |
| slot_sel | input | 1 | Time slot used after a sync pulse (0 first, 1 second) |
| sync_pulse | input | 1 | Decoded sync pulse from the bus, one clock wide |
| az_en | input | 1 | Include the auto-zero phase |
| selftest_ok | input | 1 | Self-test result reported in the diagnostic frame |
| serial_no | input | SN_W | Factory serial number |
| rev_id | input | 3 | Revision code |
| mfg_id | input | 3 | Manufacturer code |
| user_byte | input | 8 | User data byte |
| user_bit | input | 1 | Extra user bit, sent in its own frame |
| accel_sample | input | SAMPLE_W | Current acceleration sample |
| tx_line | output | 1 | Manchester-coded modulation line |
| tx_active | output | 1 | High while a frame is being sent |
| phase_o | output | 3 | Current phase code |

## Verification
The bench builds the block with `PERIOD`=60, `HALF_CYC`=2 and `SLOT_GAP`=10. A 60-clock period leaves only 12 idle clocks between 48-clock frames, so the whole free-running startup, through auto-zero into the normal phase, fits in under a thousand clocks. Setting `HALF_CYC` to 2 selects the counting half-bit variant of the serializer, and the monitor can see both halves of every bit. A 10-clock slot gap keeps the slot-1 delay clearly apart from slot 0. It also leaves room to place a second pulse inside the pending window and another inside a running frame.

// File: rtl/sps_pkg.sv
package sps_pkg;

   typedef enum logic [2:0] {
      PH_INIT = 3'd0,
      PH_DEV  = 3'd1,
      PH_DIAG = 3'd2,
      PH_AZ   = 3'd3,
      PH_NORM = 3'd4
   } phase_e;

   localparam int TYPE_W = 2;

   localparam logic [TYPE_W-1:0] MT_DEV  = 2'b00;
   localparam logic [TYPE_W-1:0] MT_DIAG = 2'b01;
   localparam logic [TYPE_W-1:0] MT_AZ   = 2'b10;
   localparam logic [TYPE_W-1:0] MT_ACC  = 2'b11;

endpackage

// File: rtl/sps_pacer.sv
module sps_pacer #(
   parameter int PERIOD   = 3648,
   parameter int SLOT_GAP = 1600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_en,
   input  logic slot_sel,
   input  logic sync_pulse,
   input  logic busy,
   output logic tick
);
   localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam int GAP_W = (SLOT_GAP > 0) ? $clog2(SLOT_GAP + 1) : 1;

   logic [CNT_W-1:0] per_cnt;
   logic [GAP_W-1:0] gap_cnt;
   logic             pend;
   logic             tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_cnt <= '0;
         gap_cnt <= '0;
         pend    <= 1'b0;
         tick_q  <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (!sync_en) begin
            pend <= 1'b0;
            if (per_cnt == CNT_W'(PERIOD - 1)) begin
               per_cnt <= '0;
               tick_q  <= 1'b1;
            end else begin
               per_cnt <= per_cnt + 1'b1;
            end
         end else begin
            per_cnt <= '0;
            if (pend) begin
               if (gap_cnt == '0) begin
                  pend   <= 1'b0;
                  tick_q <= 1'b1;
               end else begin
                  gap_cnt <= gap_cnt - 1'b1;
               end
            end else if (sync_pulse && !tick_q && !busy) begin
               pend    <= 1'b1;
               gap_cnt <= slot_sel ? GAP_W'(SLOT_GAP) : '0;
            end
         end
      end
   end

   assign tick = tick_q;

endmodule

// File: rtl/sps_msg_sel.sv
module sps_msg_sel
   import sps_pkg::*;
#(
   parameter int SN_W     = 32,
   parameter int SAMPLE_W = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick,
   input  logic                       az_en,
   input  logic                       selftest_ok,
   input  logic [SN_W-1:0]            serial_no,
   input  logic [2:0]                 rev_id,
   input  logic [2:0]                 mfg_id,
   input  logic [7:0]                 user_byte,
   input  logic                       user_bit,
   input  logic [SAMPLE_W-1:0]        accel_sample,
   output logic                       send,
   output logic [TYPE_W+SAMPLE_W-1:0] frame,
   output phase_e                     phase
);
   localparam int SN_BYTES = SN_W / 8;
   localparam int DEV_MSGS = SN_BYTES + 3;
   localparam int IDX_W    = $clog2(DEV_MSGS);
   localparam int ID_IDX   = SN_BYTES;
   localparam int UB_IDX   = SN_BYTES + 1;
   localparam int BIT_IDX  = SN_BYTES + 2;

   phase_e             ph_q;
   logic [IDX_W-1:0]   idx_q;
   logic [SN_W-1:0]    sn_shift;
   logic [TYPE_W-1:0]  mtype;
   logic [SAMPLE_W-1:0] data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_INIT;
         idx_q <= '0;
      end else if (tick) begin
         unique case (ph_q)
            PH_INIT: begin
               ph_q  <= PH_DEV;
               idx_q <= '0;
            end
            PH_DEV: begin
               if (idx_q == IDX_W'(DEV_MSGS - 1)) begin
                  ph_q  <= PH_DIAG;
                  idx_q <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            PH_DIAG: ph_q <= az_en ? PH_AZ : PH_NORM;
            PH_AZ:   ph_q <= PH_NORM;
            default: ph_q <= PH_NORM;
         endcase
      end
   end

   assign sn_shift = serial_no >> {idx_q, 3'b000};

   always_comb begin
      mtype = MT_DEV;
      data  = '0;
      unique case (ph_q)
         PH_DEV: begin
            mtype = MT_DEV;
            if (idx_q == IDX_W'(ID_IDX))
               data = SAMPLE_W'({2'b00, rev_id, mfg_id});
            else if (idx_q == IDX_W'(UB_IDX))
               data = SAMPLE_W'(user_byte);
            else if (idx_q == IDX_W'(BIT_IDX))
               data = SAMPLE_W'(user_bit);
            else
               data = SAMPLE_W'(sn_shift[7:0]);
         end
         PH_DIAG: begin
            mtype = MT_DIAG;
            data  = SAMPLE_W'(selftest_ok);
         end
         PH_AZ: begin
            mtype = MT_AZ;
            data  = accel_sample;
         end
         PH_NORM: begin
            mtype = MT_ACC;
            data  = accel_sample;
         end
         default: begin
            mtype = MT_DEV;
            data  = '0;
         end
      endcase
   end

   assign frame = {mtype, data};
   assign send  = tick && (ph_q != PH_INIT);
   assign phase = ph_q;

endmodule

// File: rtl/sps_manch_tx.sv
module sps_manch_tx #(
   parameter int FRAME_W  = 12,
   parameter int HALF_CYC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   output logic               line,
   output logic               busy
);
   localparam int BIT_W = $clog2(FRAME_W);

   logic [FRAME_W-1:0] shreg;
   logic [BIT_W-1:0]   bits_left;
   logic               second_half;
   logic               busy_q;
   logic               half_done;

   generate
      if (HALF_CYC > 1) begin : g_half_cnt
         localparam int HC_W = $clog2(HALF_CYC);
         logic [HC_W-1:0] hcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hcnt <= '0;
            else if (load || !busy_q || half_done)
               hcnt <= '0;
            else
               hcnt <= hcnt + 1'b1;
         end
         assign half_done = busy_q && (hcnt == HC_W'(HALF_CYC - 1));
      end else begin : g_half_one
         assign half_done = busy_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg       <= '0;
         bits_left   <= '0;
         second_half <= 1'b0;
         busy_q      <= 1'b0;
      end else if (load) begin
         shreg       <= frame;
         bits_left   <= BIT_W'(FRAME_W - 1);
         second_half <= 1'b0;
         busy_q      <= 1'b1;
      end else if (half_done) begin
         if (!second_half) begin
            second_half <= 1'b1;
         end else begin
            second_half <= 1'b0;
            if (bits_left == '0) begin
               busy_q <= 1'b0;
            end else begin
               bits_left <= bits_left - 1'b1;
               shreg     <= {shreg[FRAME_W-2:0], 1'b0};
            end
         end
      end
   end

   assign line = busy_q && (second_half ? shreg[FRAME_W-1] : ~shreg[FRAME_W-1]);
   assign busy = busy_q;

endmodule

// File: rtl/sensor_phase_seq.sv
module sensor_phase_seq
   import sps_pkg::*;
#(
   parameter int SN_W     = 32,
   parameter int SAMPLE_W = 10,
   parameter int HALF_CYC = 8,
   parameter int PERIOD   = 3648,
   parameter int SLOT_GAP = 1600
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sync_en,
   input  logic                slot_sel,
   input  logic                sync_pulse,
   input  logic                az_en,
   input  logic                selftest_ok,
   input  logic [SN_W-1:0]     serial_no,
   input  logic [2:0]          rev_id,
   input  logic [2:0]          mfg_id,
   input  logic [7:0]          user_byte,
   input  logic                user_bit,
   input  logic [SAMPLE_W-1:0] accel_sample,
   output logic                tx_line,
   output logic                tx_active,
   output logic [2:0]          phase_o
);
   localparam int FRAME_W  = TYPE_W + SAMPLE_W;
   localparam int TX_CYC   = 2 * FRAME_W * HALF_CYC;

   generate
      if (SN_W % 8 != 0 || SN_W < 8) begin : g_bad_sn
         $error("SN_W must be a positive multiple of 8");
      end
      if (SAMPLE_W < 8) begin : g_bad_sample
         $error("SAMPLE_W must hold a byte");
      end
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (PERIOD < TX_CYC + 2) begin : g_bad_period
         $error("PERIOD too short for one frame");
      end
   endgenerate

   logic               tick;
   logic               send;
   logic               busy;
   logic [FRAME_W-1:0] frame;
   phase_e             phase;

   sps_pacer #(
      .PERIOD   (PERIOD),
      .SLOT_GAP (SLOT_GAP)
   ) u_pacer (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_en    (sync_en),
      .slot_sel   (slot_sel),
      .sync_pulse (sync_pulse),
      .busy       (busy),
      .tick       (tick)
   );

   sps_msg_sel #(
      .SN_W     (SN_W),
      .SAMPLE_W (SAMPLE_W)
   ) u_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .az_en        (az_en),
      .selftest_ok  (selftest_ok),
      .serial_no    (serial_no),
      .rev_id       (rev_id),
      .mfg_id       (mfg_id),
      .user_byte    (user_byte),
      .user_bit     (user_bit),
      .accel_sample (accel_sample),
      .send         (send),
      .frame        (frame),
      .phase        (phase)
   );

   sps_manch_tx #(
      .FRAME_W  (FRAME_W),
      .HALF_CYC (HALF_CYC)
   ) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (send),
      .frame (frame),
      .line  (tx_line),
      .busy  (busy)
   );

   assign tx_active = busy;
   assign phase_o   = phase;

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
   parameter int FRAME_W  = 12,
   parameter int HALF_CYC = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       az_en,
   input logic       tx_line,
   input logic       tx_active,
   input logic [2:0] phase_o
);
   localparam logic [31:0] TX_LEN = 32'(2 * FRAME_W * HALF_CYC);

   logic [31:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_len <= '0;
      else if (tx_active)
         run_len <= run_len + 1'b1;
      else
         run_len <= '0;
   end

   a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active |-> !tx_line);

   a_r10_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_active) |-> (run_len == TX_LEN));

   a_r2_no_tx_in_init: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd0) |-> !tx_active);

   a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_o) |->
         (($past(phase_o) == 3'd0 && phase_o == 3'd1) ||
          ($past(phase_o) == 3'd1 && phase_o == 3'd2) ||
          ($past(phase_o) == 3'd2 && (phase_o == 3'd3 || phase_o == 3'd4)) ||
          ($past(phase_o) == 3'd3 && phase_o == 3'd4)));

   a_r5_az_only_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd3 && !$stable(phase_o)) |-> az_en);

   a_r2_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o <= 3'd4);

endmodule

bind sensor_phase_seq sps_checker #(
   .FRAME_W  (FRAME_W),
   .HALF_CYC (HALF_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .az_en     (az_en),
   .tx_line   (tx_line),
   .tx_active (tx_active),
   .phase_o   (phase_o)
);

// File: tb/sensor_phase_seq_tb.sv
`timescale 1ns/1ps
module sensor_phase_seq_tb;
   localparam int SN_W     = 32;
   localparam int SAMPLE_W = 10;
   localparam int HALF_CYC = 2;
   localparam int PERIOD   = 60;
   localparam int SLOT_GAP = 10;
   localparam int FW       = 12;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                sync_en = 1'b0;
   logic                slot_sel = 1'b0;
   logic                sync_pulse = 1'b0;
   logic                az_en = 1'b1;
   logic                selftest_ok = 1'b1;
   logic [SN_W-1:0]     serial_no = 32'hA5C3_1E7B;
   logic [2:0]          rev_id = 3'b101;
   logic [2:0]          mfg_id = 3'b011;
   logic [7:0]          user_byte = 8'h96;
   logic                user_bit = 1'b1;
   logic [SAMPLE_W-1:0] accel_sample = 10'h2D5;
   logic                tx_line;
   logic                tx_active;
   logic [2:0]          phase_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int rcv_count = 0;
   int last_start = 0;
   int prev_start = 0;
   bit have_prev = 1'b0;
   logic [FW-1:0] exp_q[$];
   string         tag_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sensor_phase_seq #(
      .SN_W     (SN_W),
      .SAMPLE_W (SAMPLE_W),
      .HALF_CYC (HALF_CYC),
      .PERIOD   (PERIOD),
      .SLOT_GAP (SLOT_GAP)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sync_en      (sync_en),
      .slot_sel     (slot_sel),
      .sync_pulse   (sync_pulse),
      .az_en        (az_en),
      .selftest_ok  (selftest_ok),
      .serial_no    (serial_no),
      .rev_id       (rev_id),
      .mfg_id       (mfg_id),
      .user_byte    (user_byte),
      .user_bit     (user_bit),
      .accel_sample (accel_sample),
      .tx_line      (tx_line),
      .tx_active    (tx_active),
      .phase_o      (phase_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic expect_frame(input logic [FW-1:0] f, input string req);
      exp_q.push_back(f);
      tag_q.push_back(req);
   endtask

   // Monitor: decodes Manchester frames and compares with the scoreboard queue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && tx_active) begin
            logic [FW-1:0] got;
            bit            coding_ok;
            got        = '0;
            coding_ok  = 1'b1;
            last_start = cyc;
            if (!sync_en && have_prev)
               check(last_start - prev_start == PERIOD, "R7 frame spacing",
                     32'(last_start - prev_start), 32'(PERIOD));
            prev_start = last_start;
            have_prev  = 1'b1;
            for (int b = 0; b < FW; b++) begin
               logic h1;
               logic h2;
               h1 = tx_line;
               repeat (HALF_CYC) @(negedge clk);
               h2 = tx_line;
               repeat (HALF_CYC) @(negedge clk);
               if (h1 == h2) coding_ok = 1'b0;
               got = {got[FW-2:0], h2};
            end
            check(coding_ok, "R10 mid-bit transition", 32'(coding_ok), 32'd1);
            check(!tx_active, "R10 active length", 32'(tx_active), 32'd0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected frame", 32'(got), 32'hFFFF_FFFF);
            end else begin
               logic [FW-1:0] e;
               string         t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(got == e, t, 32'(got), 32'(e));
            end
            rcv_count++;
         end
      end
   end

   task automatic do_reset(input bit mode_sync);
      @(negedge clk);
      rst_n     = 1'b0;
      sync_en   = mode_sync;
      have_prev = 1'b0;
      repeat (3) @(negedge clk);
      check(phase_o == 3'd0, "R1 phase in reset", 32'(phase_o), 32'd0);
      check(!tx_line && !tx_active, "R1 line idle in reset",
            {30'd0, tx_line, tx_active}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(phase_o == 3'd0 && !tx_active, "R1 state after release",
            {28'd0, tx_active, phase_o}, 32'd0);
   endtask

   // mode: 0 plain, 1 second pulse mid-frame, 2 second pulse while slot pending
   task automatic sync_tick(input bit slot, input bit exp_msg, input int mode);
      int acc;
      int prev;
      prev = rcv_count;
      @(negedge clk);
      slot_sel   = slot;
      sync_pulse = 1'b1;
      @(negedge clk);
      sync_pulse = 1'b0;
      acc = cyc;
      if (mode == 1) begin
         repeat (20) @(negedge clk);
         sync_pulse = 1'b1;
         @(negedge clk);
         sync_pulse = 1'b0;
      end else if (mode == 2) begin
         repeat (3) @(negedge clk);
         sync_pulse = 1'b1;
         @(negedge clk);
         sync_pulse = 1'b0;
      end
      if (exp_msg) begin
         for (int k = 0; k < 400 && rcv_count == prev; k++) @(negedge clk);
         check(rcv_count == prev + 1, "R8 frame after pulse",
               32'(rcv_count - prev), 32'd1);
         check(last_start - acc == (slot ? SLOT_GAP + 2 : 2), "R8 slot delay",
               32'(last_start - acc), 32'(slot ? SLOT_GAP + 2 : 2));
         repeat (SLOT_GAP + 8) @(negedge clk);
         if (mode != 0)
            check(rcv_count == prev + 1 && !tx_active, "R9 extra pulse dropped",
                  32'(rcv_count - prev), 32'd1);
      end else begin
         repeat (SLOT_GAP + 8) @(negedge clk);
         check(rcv_count == prev, "R2 init tick sends nothing",
               32'(rcv_count - prev), 32'd0);
      end
   endtask

   task automatic push_dev;
      expect_frame(12'h07B, "R3 serial byte 0");
      expect_frame(12'h01E, "R3 serial byte 1");
      expect_frame(12'h0C3, "R3 serial byte 2");
      expect_frame(12'h0A5, "R3 serial byte 3");
      expect_frame(12'h02B, "R3 id byte");
      expect_frame(12'h096, "R3 user byte");
      expect_frame(12'h001, "R3 user bit");
   endtask

   // Driver
   initial begin
      // Run 1: free-running, auto-zero on, self-test pass
      az_en       = 1'b1;
      selftest_ok = 1'b1;
      push_dev();
      expect_frame(12'h401, "R4 diag pass");
      expect_frame(12'hAD5, "R5 auto-zero frame");
      expect_frame(12'hED5, "R6 normal sample");
      expect_frame(12'hED5, "R6 normal repeat");
      do_reset(1'b0);
      check(phase_o == 3'd0, "R2 still init before first period",
            32'(phase_o), 32'd0);
      for (int k = 0; k < 2000 && rcv_count < 3; k++) @(negedge clk);
      repeat (5) begin
         @(negedge clk);
         sync_pulse = 1'b1;
         @(negedge clk);
         sync_pulse = 1'b0;
         repeat (7) @(negedge clk);
      end
      for (int k = 0; k < 2000 && rcv_count < 11; k++) @(negedge clk);
      check(rcv_count == 11 && exp_q.size() == 0, "R7 run 1 frame count",
            32'(rcv_count), 32'd11);
      check(phase_o == 3'd4, "R6 stays in normal", 32'(phase_o), 32'd4);

      // Run 2: sync pulses, auto-zero off, self-test fail
      az_en       = 1'b0;
      selftest_ok = 1'b0;
      do_reset(1'b1);
      rcv_count = 0;
      repeat (3 * PERIOD) @(negedge clk);
      check(rcv_count == 0 && phase_o == 3'd0, "R8 no frame without pulse",
            {rcv_count[28:0], phase_o}, 32'd0);
      sync_tick(1'b0, 1'b0, 0);
      check(phase_o == 3'd1, "R2 init to device data", 32'(phase_o), 32'd1);
      push_dev();
      sync_tick(1'b0, 1'b1, 0);
      sync_tick(1'b1, 1'b1, 0);
      sync_tick(1'b0, 1'b1, 1);
      sync_tick(1'b1, 1'b1, 2);
      sync_tick(1'b0, 1'b1, 0);
      sync_tick(1'b1, 1'b1, 0);
      sync_tick(1'b0, 1'b1, 0);
      check(phase_o == 3'd2, "R2 device data to diag", 32'(phase_o), 32'd2);
      expect_frame(12'h400, "R4 diag fail");
      sync_tick(1'b1, 1'b1, 0);
      check(phase_o == 3'd4, "R5 auto-zero skipped", 32'(phase_o), 32'd4);
      accel_sample = 10'h001;
      expect_frame(12'hC01, "R6 sample low");
      sync_tick(1'b0, 1'b1, 0);
      accel_sample = 10'h3FF;
      expect_frame(12'hFFF, "R6 sample full");
      sync_tick(1'b1, 1'b1, 0);
      repeat (100) @(negedge clk);
      check(exp_q.size() == 0 && rcv_count == 10, "R9 run 2 frame count",
            32'(rcv_count), 32'd10);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule